// File: doc/BRIEF.md
# External Data Space Access Qualifier

This block sits on the external data bus of an 8051-class microcontroller and sorts every MOVX access by its 16-bit address. An address in the bottom 94 bytes is a configuration or control register access. An address in the rest of the bottom 4 Kbytes is an on-chip SRAM access. Every higher address goes off-chip. For the two on-chip classes the block raises a select and gives a zero-based index into the target. For off-chip accesses it drives the read and write pins.

The internal read and write strobes are active low. While an access targets the on-chip range, the pin drivers stay disabled, so the pins are high-impedance, and the strobes never reach them. For an off-chip address the strobes pass straight through and the output-enable is raised for the length of the strobe. Off-chip RAM therefore needs no chip-select decoder. The price is that its lowest 4 Kbytes are hidden behind the on-chip resources.

The decode is combinational. A copy of the three selects, registered on the clock, is also provided for logic downstream that needs a timing break.

Top module: `xdata_qualifier`

## Requirements
- R1: With a strobe active (rd_n or wr_n low) and an address from 0000h to 005Dh, reg_sel is 1 and reg_index equals the address (7 bits).
- R2: With a strobe active and an address from 005Eh to 0FFFh, sram_sel is 1 and sram_index equals the address minus 005Eh (12 bits).
- R3: With a strobe active and an address at or above 1000h, pin_oe is 1, rd_pin equals rd_n and wr_pin equals wr_n.
- R4: For any address below 1000h, pin_oe is 0 and rd_pin and wr_pin rest at 1, whatever the strobes do. Off-chip locations below 1000h are never reached.
- R5: With both strobes high, reg_sel, sram_sel and pin_oe are all 0.
- R6: At most one of reg_sel, sram_sel and pin_oe is 1 at any time.
- R7: reg_sel_q, sram_sel_q and ext_sel_q equal reg_sel, sram_sel and pin_oe of the previous clock cycle.
- R8: While rst_n is low, reg_sel_q, sram_sel_q and ext_sel_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered selects |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | External data address |
| rd_n | input | 1 | Internal read strobe, active low |
| wr_n | input | 1 | Internal write strobe, active low |
| reg_sel | output | 1 | Register file access in progress |
| reg_index | output | 7 | Register number within the register file |
| sram_sel | output | 1 | On-chip SRAM access in progress |
| sram_index | output | 12 | Word offset into the on-chip SRAM |
| rd_pin | output | 1 | Read pin level, valid while pin_oe is 1 |
| wr_pin | output | 1 | Write pin level, valid while pin_oe is 1 |
| pin_oe | output | 1 | Pin driver enable; 0 means high-impedance |
| reg_sel_q | output | 1 | reg_sel delayed one clock |
| sram_sel_q | output | 1 | sram_sel delayed one clock |
| ext_sel_q | output | 1 | pin_oe delayed one clock |

## Verification
A wrong region boundary shows at the ports in the same cycle as the access. An address just on either side of 005Eh or 1000h raises the wrong select, gives an index off by one, or lets a strobe leak onto the pins. A fault in the registered copy shows one clock later on the _q outputs. A missing reset shows in the first cycle of reset. The stimulus therefore weights addresses around both boundaries and the address extremes, and it toggles each strobe alone and the two together.

// File: rtl/xdq_pkg.sv
package xdq_pkg;

  typedef enum logic [1:0] {
    XR_REG  = 2'd0,
    XR_SRAM = 2'd1,
    XR_EXT  = 2'd2
  } xdq_region_e;

  typedef struct packed {
    logic regf;
    logic sram;
    logic ext;
  } xdq_sel_t;

endpackage

// File: rtl/xdq_region_decode.sv
module xdq_region_decode
  import xdq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REG_COUNT   = 94,
  parameter int ONCHIP_SIZE = 4096,
  localparam int REG_AW     = $clog2(REG_COUNT),
  localparam int SRAM_AW    = $clog2(ONCHIP_SIZE - REG_COUNT)
) (
  input  logic [ADDR_W-1:0]  addr,
  output xdq_region_e        region,
  output logic [REG_AW-1:0]  reg_index,
  output logic [SRAM_AW-1:0] sram_index
);

  localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] EXT_BASE  = ADDR_W'(ONCHIP_SIZE);

  function automatic xdq_region_e classify(input logic [ADDR_W-1:0] a);
    if (a < SRAM_BASE)     return XR_REG;
    else if (a < EXT_BASE) return XR_SRAM;
    else                   return XR_EXT;
  endfunction

  function automatic logic [ADDR_W-1:0] sram_offset(input logic [ADDR_W-1:0] a);
    return a - SRAM_BASE;
  endfunction

  logic [ADDR_W-1:0] sram_diff;

  always_comb begin
    region     = classify(addr);
    sram_diff  = sram_offset(addr);
    reg_index  = '0;
    sram_index = '0;
    if (region == XR_REG)  reg_index  = REG_AW'(addr);
    if (region == XR_SRAM) sram_index = SRAM_AW'(sram_diff);
  end

endmodule

// File: rtl/xdq_strobe_gate.sv
module xdq_strobe_gate
  import xdq_pkg::*;
(
  input  xdq_region_e region,
  input  logic        rd_n,
  input  logic        wr_n,
  output xdq_sel_t    sel,
  output logic        rd_pin,
  output logic        wr_pin,
  output logic        pin_oe
);

  logic strobe_on;

  always_comb begin
    strobe_on = ~(rd_n & wr_n);
    sel.regf  = strobe_on && (region == XR_REG);
    sel.sram  = strobe_on && (region == XR_SRAM);
    sel.ext   = strobe_on && (region == XR_EXT);
    pin_oe    = sel.ext;
    rd_pin    = sel.ext ? rd_n : 1'b1;
    wr_pin    = sel.ext ? wr_n : 1'b1;
  end

endmodule

// File: rtl/xdq_sel_pipe.sv
module xdq_sel_pipe
  import xdq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  xdq_sel_t sel_d,
  output xdq_sel_t sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

endmodule

// File: rtl/xdata_qualifier.sv
module xdata_qualifier
  import xdq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REG_COUNT   = 94,
  parameter int ONCHIP_SIZE = 4096,
  localparam int REG_AW     = $clog2(REG_COUNT),
  localparam int SRAM_AW    = $clog2(ONCHIP_SIZE - REG_COUNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic               reg_sel,
  output logic [REG_AW-1:0]  reg_index,
  output logic               sram_sel,
  output logic [SRAM_AW-1:0] sram_index,
  output logic               rd_pin,
  output logic               wr_pin,
  output logic               pin_oe,
  output logic               reg_sel_q,
  output logic               sram_sel_q,
  output logic               ext_sel_q
);

  xdq_region_e region_w;
  xdq_sel_t    sel_w;
  xdq_sel_t    sel_q_w;

  xdq_region_decode #(
    .ADDR_W      (ADDR_W),
    .REG_COUNT   (REG_COUNT),
    .ONCHIP_SIZE (ONCHIP_SIZE)
  ) u_decode (
    .addr       (addr),
    .region     (region_w),
    .reg_index  (reg_index),
    .sram_index (sram_index)
  );

  xdq_strobe_gate u_gate (
    .region (region_w),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .sel    (sel_w),
    .rd_pin (rd_pin),
    .wr_pin (wr_pin),
    .pin_oe (pin_oe)
  );

  xdq_sel_pipe u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_d (sel_w),
    .sel_q (sel_q_w)
  );

  assign reg_sel    = sel_w.regf;
  assign sram_sel   = sel_w.sram;
  assign reg_sel_q  = sel_q_w.regf;
  assign sram_sel_q = sel_q_w.sram;
  assign ext_sel_q  = sel_q_w.ext;

endmodule

// File: rtl/xdata_qualifier_chk.sv
module xdata_qualifier_chk #(
  parameter int ADDR_W      = 16,
  parameter int REG_COUNT   = 94,
  parameter int ONCHIP_SIZE = 4096,
  localparam int REG_AW     = $clog2(REG_COUNT),
  localparam int SRAM_AW    = $clog2(ONCHIP_SIZE - REG_COUNT)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               rd_n,
  input logic               wr_n,
  input logic               reg_sel,
  input logic [REG_AW-1:0]  reg_index,
  input logic               sram_sel,
  input logic [SRAM_AW-1:0] sram_index,
  input logic               rd_pin,
  input logic               wr_pin,
  input logic               pin_oe,
  input logic               reg_sel_q,
  input logic               sram_sel_q,
  input logic               ext_sel_q
);

  localparam logic [ADDR_W-1:0] LO_SRAM = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] LO_EXT  = ADDR_W'(ONCHIP_SIZE);

  wire busy    = !(rd_n && wr_n);
  wire in_reg  = addr < LO_SRAM;
  wire in_chip = addr < LO_EXT;

  // R1
  a_r1_reg_select: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_reg) |-> (reg_sel && reg_index == REG_AW'(addr)));

  // R2
  a_r2_sram_select: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_reg && in_chip) |-> (sram_sel && sram_index == SRAM_AW'(addr - LO_SRAM)));

  // R3
  a_r3_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_chip) |-> (pin_oe && rd_pin == rd_n && wr_pin == wr_n));

  // R4
  a_r4_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_chip |-> (!pin_oe && rd_pin && wr_pin));

  // R5
  a_r5_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(reg_sel || sram_sel || pin_oe));

  // R6
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_sel, sram_sel, pin_oe}));

  // R7
  a_r7_delayed: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (reg_sel_q == $past(reg_sel) && sram_sel_q == $past(sram_sel)
               && ext_sel_q == $past(pin_oe)));

  // R8
  always_comb begin
    if (!rst_n) begin
      a_r8_reset_clear: assert (!(reg_sel_q || sram_sel_q || ext_sel_q) || $time == 0);
    end
  end

endmodule

bind xdata_qualifier xdata_qualifier_chk #(
  .ADDR_W      (ADDR_W),
  .REG_COUNT   (REG_COUNT),
  .ONCHIP_SIZE (ONCHIP_SIZE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .reg_sel    (reg_sel),
  .reg_index  (reg_index),
  .sram_sel   (sram_sel),
  .sram_index (sram_index),
  .rd_pin     (rd_pin),
  .wr_pin     (wr_pin),
  .pin_oe     (pin_oe),
  .reg_sel_q  (reg_sel_q),
  .sram_sel_q (sram_sel_q),
  .ext_sel_q  (ext_sel_q)
);

// File: tb/xdata_qualifier_tb.sv
module xdata_qualifier_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        reg_sel, sram_sel, rd_pin, wr_pin, pin_oe;
  logic        reg_sel_q, sram_sel_q, ext_sel_q;
  logic [6:0]  reg_index;
  logic [11:0] sram_index;

  int checks = 0;
  int fails  = 0;
  bit prev_valid = 1'b0;
  logic [2:0] prev_sel = 3'b000;

  always #4 clk = ~clk;

  xdata_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .reg_sel(reg_sel), .reg_index(reg_index), .sram_sel(sram_sel),
    .sram_index(sram_index), .rd_pin(rd_pin), .wr_pin(wr_pin), .pin_oe(pin_oe),
    .reg_sel_q(reg_sel_q), .sram_sel_q(sram_sel_q), .ext_sel_q(ext_sel_q)
  );

  // expected selects {reg, sram, ext} from the requirement address ranges
  function automatic logic [2:0] exp_sel(input logic [15:0] a, input logic r, input logic w);
    if (r && w)           return 3'b000;
    if (a <= 16'h005D)    return 3'b100;
    if (a <= 16'h0FFF)    return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic [11:0] exp_sram_idx(input logic [15:0] a);
    int d;
    d = int'(a) - 94;
    return d[11:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h addr=%04h rd_n=%b wr_n=%b", req, act, exp, addr, rd_n, wr_n);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic r, input logic w);
    logic [2:0] e;
    @(negedge clk);
    if (prev_valid)
      check({reg_sel_q, sram_sel_q, ext_sel_q} == prev_sel, "R7",
            {29'd0, reg_sel_q, sram_sel_q, ext_sel_q}, {29'd0, prev_sel});
    addr = a; rd_n = r; wr_n = w;
    #1;
    e = exp_sel(a, r, w);
    check({reg_sel, sram_sel, pin_oe} == e, "R6",
          {29'd0, reg_sel, sram_sel, pin_oe}, {29'd0, e});
    if (e == 3'b000)
      check(!(reg_sel || sram_sel || pin_oe), "R5", {29'd0, reg_sel, sram_sel, pin_oe}, 32'd0);
    if (e == 3'b100)
      check(reg_sel && reg_index == a[6:0], "R1", {24'd0, reg_sel, reg_index}, {24'd0, 1'b1, a[6:0]});
    if (e == 3'b010)
      check(sram_sel && sram_index == exp_sram_idx(a), "R2",
            {19'd0, sram_sel, sram_index}, {19'd0, 1'b1, exp_sram_idx(a)});
    if (a >= 16'h1000) begin
      if (e == 3'b001)
        check(pin_oe && rd_pin == r && wr_pin == w, "R3",
              {29'd0, pin_oe, rd_pin, wr_pin}, {29'd0, 1'b1, r, w});
    end else begin
      check(!pin_oe && rd_pin && wr_pin, "R4",
            {29'd0, pin_oe, rd_pin, wr_pin}, {29'd0, 3'b011});
    end
    prev_sel   = e;
    prev_valid = 1'b1;
  endtask

  function automatic logic [15:0] pick_addr(input int unsigned k);
    case (k % 6)
      0: return 16'h005E + 16'(($urandom % 9)) - 16'd4;
      1: return 16'h1000 + 16'(($urandom % 9)) - 16'd4;
      2: return 16'($urandom % 94);
      3: return 16'($urandom % 16'h1000);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R8: strobe active during reset, registered selects must stay 0
    addr = 16'h2000; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check({reg_sel_q, sram_sel_q, ext_sel_q} == 3'b000, "R8",
          {29'd0, reg_sel_q, sram_sel_q, ext_sel_q}, 32'd0);
    addr = 16'h0010;
    @(negedge clk);
    check({reg_sel_q, sram_sel_q, ext_sel_q} == 3'b000, "R8",
          {29'd0, reg_sel_q, sram_sel_q, ext_sel_q}, 32'd0);
    rd_n = 1'b1;
    rst_n = 1'b1;

    // directed boundary cases
    apply(16'h0000, 1'b0, 1'b1);
    apply(16'h005D, 1'b1, 1'b0);
    apply(16'h005E, 1'b0, 1'b1);
    apply(16'h0FFF, 1'b1, 1'b0);
    apply(16'h1000, 1'b0, 1'b1);
    apply(16'h1000, 1'b1, 1'b0);
    apply(16'hFFFF, 1'b0, 1'b0);
    apply(16'h0800, 1'b0, 1'b0);
    apply(16'h0800, 1'b1, 1'b1);
    apply(16'h4000, 1'b1, 1'b1);
    apply(16'h0000, 1'b1, 1'b1);

    for (int i = 0; i < 2000; i++) begin
      int unsigned s;
      logic r, w;
      s = $urandom % 8;
      r = !(s == 0 || s == 1 || s == 2 || s == 6);
      w = !(s == 3 || s == 4 || s == 5 || s == 6);
      apply(pick_addr(i), r, w);
    end
    apply(16'h0000, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule